// File: doc/BRIEF.md
# Flash Completion Poll Sequencer

This block runs on the host side of a parallel flash interface. Software issues a program or erase command by other means. It then pulses `start` with the address to watch and the datum that was written. The sequencer repeatedly reads the status byte at that address through a simple request/valid read port. It compares bit 7 with the value that marks completion, and it watches bit 5 as the device's timeout flag.

A timeout flag alone never ends the operation as failed. Bit 7 and bit 5 can flip in the same device cycle, so once bit 5 is seen set the sequencer makes one more read and decides on bit 7 of that read. A parameterised limit on the number of reads stops the sequencer if the device never completes. The outcome is reported as a single-cycle `done` pulse that carries exactly one of `pass` or `fail`. After that pulse the sequencer is idle again.

Bit positions are fixed by the device: bit 7 is the completion bit and bit 5 is the timeout bit. In erase mode completion means bit 7 reads 1, because erased cells read as ones. After a pass, the full byte at the address is valid from the next read cycle onward. Performing that read is left to the host.

Top module: `flash_poll_ctrl`

## Requirements
- R1: During and after reset, until a start is accepted, `rd_req`, `done`, `pass` and `fail` are all 0.
- R2: After a start is accepted in idle, `rd_req` is 1 from the next cycle and stays 1 until the deciding read returns. `rd_addr` equals the `addr` captured with the start for every read of the operation.
- R3: In program mode (`erase_mode`=0) the target is `exp_data[7]`. A read whose `rd_data[7]` equals the target ends the operation with pass.
- R4: A read whose `rd_data[7]` differs from the target and whose `rd_data[5]` is 0 is followed by another read, as long as the read limit has not been reached.
- R5: A read whose bit 7 differs from the target and whose bit 5 is 1 is followed by exactly one more read. If bit 7 of that read equals the target, the result is pass.
- R6: If bit 7 of that follow-up read still differs from the target, the result is fail and no further read is made.
- R7: In erase mode (`erase_mode`=1) the target is 1 whatever `exp_data` holds.
- R8: If read number MAX_POLLS of an operation mismatches, the result is fail with no further read, even when its bit 5 is 1.
- R9: `done` is high for exactly one cycle, in the cycle after the deciding `rd_valid`, with exactly one of `pass`/`fail` high. `pass` and `fail` are 0 whenever `done` is 0. In the cycle after `done`, `rd_req` is 0.
- R10: A `start` pulse while an operation is in progress is ignored. It changes neither the address, the target nor the number of reads, and it produces no extra `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin polling (taken only when idle) |
| addr | input | ADDR_W | Address to poll |
| exp_data | input | 8 | Datum written by the program command |
| erase_mode | input | 1 | 1: erase completion (target bit 7 = 1) |
| rd_req | output | 1 | Read request, held until `rd_valid` |
| rd_addr | output | ADDR_W | Read address |
| rd_valid | input | 1 | Read data strobe |
| rd_data | input | 8 | Status byte returned by the read |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Operation completed, valid with `done` |
| fail | output | 1 | Operation failed or timed out, valid with `done` |

## Verification
The bench builds the block with MAX_POLLS=6 and ADDR_W=16. The small read limit puts the exhausted-limit failure in reach within a handful of reads, including the case where the timeout bit rises on the last permitted read. A behavioural device model answers each request from a scripted list of status bytes. Its response latency is varied between zero and several cycles, which covers both back-to-back reads and held requests, and lets a second start be inserted mid-operation.

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl #(
  parameter int ADDR_W    = 20,
  parameter int MAX_POLLS = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        exp_data,
  input  logic              erase_mode,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [7:0]        rd_data,
  output logic              done,
  output logic              pass,
  output logic              fail
);
  localparam int CNT_W = $clog2(MAX_POLLS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MAX_POLLS - 1);

  typedef enum logic [1:0] {S_IDLE, S_POLL, S_RECHK, S_DONE} st_t;

  st_t              st;
  logic [CNT_W-1:0] polls;
  logic [ADDR_W-1:0] addr_q;
  logic             target;
  logic             verdict;
  logic             hit;

  assign hit     = rd_data[7] == target;
  assign rd_req  = (st == S_POLL) || (st == S_RECHK);
  assign rd_addr = addr_q;
  assign done    = st == S_DONE;
  assign pass    = done & verdict;
  assign fail    = done & ~verdict;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      polls   <= '0;
      addr_q  <= '0;
      target  <= 1'b0;
      verdict <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          addr_q <= addr;
          target <= erase_mode | exp_data[7];
          polls  <= '0;
          st     <= S_POLL;
        end
        S_POLL: if (rd_valid) begin
          polls <= polls + 1'b1;
          if (hit) begin
            verdict <= 1'b1;
            st      <= S_DONE;
          end else if (polls == LAST) begin
            verdict <= 1'b0;
            st      <= S_DONE;
          end else if (rd_data[5]) begin
            st <= S_RECHK;
          end
        end
        S_RECHK: if (rd_valid) begin
          verdict <= hit;
          st      <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_one_verdict_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pass ^ fail));
  assert_quiet_verdict_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (!pass && !fail));
  assert_idle_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !rd_req));
  assert_req_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));
  assert_done_after_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(rd_valid && rd_req));
endmodule

// File: tb/flash_poll_ctrl_tb_top.sv
`timescale 1ns/1ps
module flash_poll_ctrl_tb_top;
  localparam int AW = 16;
  localparam int MP = 6;

  logic clk = 0, rst_n = 0, start = 0, erase_mode = 0, rd_valid = 0;
  logic [AW-1:0] addr = '0;
  logic [7:0] exp_data = '0, rd_data = '0;
  logic rd_req, done, pass, fail;
  logic [AW-1:0] rd_addr;

  flash_poll_ctrl #(.ADDR_W(AW), .MAX_POLLS(MP)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .addr(addr), .exp_data(exp_data),
    .erase_mode(erase_mode), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .pass(pass), .fail(fail));

  always #4 clk = ~clk;

  int total = 0, bad = 0, cycles = 0;
  logic [7:0] script [16];
  int nreads = 0, lat = 0, wcnt = 0, addr_bad = 0;
  logic [AW-1:0] want_addr = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // device model: answers each request after lat idle cycles from the script
  initial begin
    forever begin
      @(negedge clk);
      rd_valid = 0;
      if (rd_req) begin
        if (wcnt >= lat) begin
          rd_valid = 1;
          rd_data = script[nreads < 16 ? nreads : 15];
          if (rd_addr !== want_addr) addr_bad++;
          nreads++;
          wcnt = 0;
        end else wcnt++;
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        chk(0, "watchdog", cycles, 100000);
        finish_run();
      end
    end
  end

  task automatic fill(input logic [7:0] v);
    for (int i = 0; i < 16; i++) script[i] = v;
  endtask

  // start one operation, optionally poke a second start mid-run, wait for done
  task automatic run(input string req, input logic er, input logic [7:0] ed,
                     input logic [AW-1:0] a, input int l, input bit poke,
                     input bit exp_pass, input int exp_reads);
    int dones = 0, n = 0;
    bit seen = 0, rq_after = 0, mixed = 0;
    lat = l; wcnt = 0; nreads = 0; addr_bad = 0; want_addr = a;
    @(negedge clk);
    start = 1; erase_mode = er; exp_data = ed; addr = a;
    @(negedge clk);
    start = 0;
    for (int c = 0; c < 300; c++) begin
      if (poke && c == 2) begin
        start = 1; addr = ~a; erase_mode = ~er; exp_data = ~ed;
      end else start = 0;
      @(negedge clk);
      if (!done && (pass || fail)) mixed = 1;
      if (done) begin
        dones++;
        if (!seen) begin
          seen = 1;
          n = 0;
          chk(pass == exp_pass && fail == !exp_pass, {req, " verdict"},
              pass, exp_pass);
          chk(nreads == exp_reads, {req, " reads"}, nreads, exp_reads);
        end
      end else if (seen) begin
        n++;
        if (n == 1 && rd_req) rq_after = 1;
        if (n == 6) break;
      end
    end
    start = 0;
    chk(seen && dones == 1, {req, " R9 single done"}, dones, 1);
    chk(!rq_after && !mixed, {req, " R9 idle after done"}, rq_after + mixed, 0);
    chk(addr_bad == 0, {req, " R2 address"}, addr_bad, 0);
  endtask

  task automatic t_reset();
    chk(!rd_req && !done && !pass && !fail, "R1 reset outputs",
        {rd_req, done, pass, fail}, 0);
  endtask

  task automatic t_program_loop();
    fill(8'h80);
    script[0] = 8'h00; script[1] = 8'h01; script[2] = 8'h7f;
    run("R3 R4 program loop", 0, 8'h80, 16'h1234, 0, 0, 1, 4);
  endtask

  task automatic t_program_zero_target();
    fill(8'h00);
    script[0] = 8'h80; script[1] = 8'hff;
    run("R3 program target 0", 0, 8'h3c, 16'h0042, 2, 0, 1, 3);
  endtask

  task automatic t_erase();
    fill(8'hff);
    script[0] = 8'h00; script[1] = 8'h10;
    run("R7 erase ignores exp_data", 1, 8'h00, 16'h8000, 1, 0, 1, 3);
  endtask

  task automatic t_to_then_pass();
    fill(8'h80);
    script[0] = 8'h20;
    run("R5 timeout recheck pass", 0, 8'hff, 16'h0aa0, 0, 0, 1, 2);
  endtask

  task automatic t_to_and_hit();
    fill(8'h00);
    script[0] = 8'ha0;
    run("R5 bit5 with bit7 true", 1, 8'h00, 16'h0003, 0, 0, 1, 1);
  endtask

  task automatic t_to_then_fail();
    fill(8'h20);
    script[0] = 8'h00; script[1] = 8'h20;
    run("R6 timeout recheck fail", 0, 8'h80, 16'h7777, 3, 0, 0, 3);
  endtask

  task automatic t_limit();
    fill(8'h00);
    run("R8 read limit", 1, 8'h00, 16'h5555, 0, 0, 0, MP);
  endtask

  task automatic t_limit_bit5();
    fill(8'h00);
    script[MP-1] = 8'h20;
    script[MP] = 8'h80;
    run("R8 limit with bit5", 0, 8'h80, 16'h5556, 1, 0, 0, MP);
  endtask

  task automatic t_busy_start();
    fill(8'h00);
    script[0] = 8'h80; script[1] = 8'h80;
    run("R10 start while busy", 0, 8'h00, 16'h0f0f, 4, 1, 1, 3);
  endtask

  initial begin
    fill(8'h00);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_program_loop();
    t_program_zero_target();
    t_erase();
    t_to_then_pass();
    t_to_and_hit();
    t_to_then_fail();
    t_limit();
    t_limit_bit5();
    t_busy_start();
    finish_run();
  end
endmodule